// File: doc/BRIEF.md
# Switch Reset and Initialization Sequencer

This controller brings a packet switch out of fundamental reset and into normal operation. It watches an active-low fundamental reset input and a software warm-reset request. It latches the boot-strap pins, then steps through a fixed bring-up order:

1. PLL and SerDes initialization.
2. Link-training start.
3. Halt-pin sample.
4. Protocol stack quasi-reset release.
5. Management-bus speed choice.
6. Slave bus release.
7. Master bus release.
8. Optional serial configuration-memory load.
9. Final halt check.

Each external agent is reached through a request that is held until that agent acknowledges it. The PLL, the link layer, the stacks, the two management-bus controllers and the memory loader are outside the block.

The block keeps halt, done and error status. While the halt bit is set it holds the switch core in reset. Software clears halt through the slave management bus. Two deadline counters run on a scaled tick: one for link-training start and one for stack readiness. A missed deadline raises a sticky timeout flag. Parameter masks decide which mode codes are test modes and which require a memory load.

Top module: `reset_sequencer`

## Requirements
- R1: On the first clock where `fund_rst_ni` is seen high after being low, the block latches the 4-bit mode strap, the slow-bus strap and the 4-bit slave address strap. `mode_o` and `ssmb_addr_o` present the latched values.
- R2: A `warm_req_i` pulse in any state other than idle gives a one-cycle `warm_cpl_o` with no request active. `pll_req_o` rises on the following cycle. The straps are not re-latched, so `mode_o` keeps its earlier value.
- R3: The requests appear in this order: `pll_req_o`, then `link_train_o`, then `stack_req_o`, then `ssmb_req_o`, then `msmb_req_o`, then `ld_req_o`. At most one request is high at a time, and each stays high until its acknowledge. `link_train_o` rises without waiting for training to finish.
- R4: If `halt_pin_i` is high when the sequence samples it (after link start), `halt_o` is set.
- R5: Mode codes whose bit is set in `TEST_MASK` are test modes, by default codes 14 and 15. A test mode skips the stack quasi-reset request, so `stack_req_o` never rises. Every other mode issues it.
- R6: `msmb_slow_o` is 1 (100 kHz) when the latched slow strap is 1, and 0 (400 kHz) otherwise. It is chosen after the stack release step.
- R7: Only mode codes whose bit is set in `LOAD_MASK` issue `ld_req_o`, by default codes 1 and 2. `done_o` is set when the load completes with `ld_done_i`, or at once when the mode needs no load.
- R8: `ld_err_i` during a load sets `err_o`, `halt_o` and `done_o`, and stores `ld_err_code_i` in `err_code_o`.
- R9: While halted, `core_rst_no` and `normal_o` stay low. A `halt_clr_i` pulse, honoured once the slave bus is released, clears `halt_o` and enters normal operation on the next cycle.
- R10: A low `fund_rst_ni` returns the sequencer to idle on the next clock. All requests drop and done, halt, error and timeout are cleared.
- R11: The tick count starts at sequence start. If link training has not started by `LT_TICKS` ticks, or a non-test mode's stack is not released by `CFG_TICKS` ticks, `timeout_o` is set. It stays set until fundamental reset.
- R12: Without halt, the sequence ends with `normal_o` and `core_rst_no` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Block power-on reset, asynchronous, active low |
| fund_rst_ni | input | 1 | Fundamental reset, synchronous, active low |
| warm_req_i | input | 1 | Software warm-reset request |
| warm_cpl_o | output | 1 | Completion pulse returned for a warm request |
| strap_mode_i | input | MODE_W | Mode strap pins |
| strap_slow_i | input | 1 | Master bus slow-speed strap |
| strap_addr_i | input | ADDR_W | Slave bus address straps |
| halt_pin_i | input | 1 | Reset-halt pin |
| tick_i | input | 1 | Scaled timer tick |
| pll_req_o | output | 1 | PLL/SerDes init request |
| pll_ack_i | input | 1 | PLL/SerDes init acknowledge |
| link_train_o | output | 1 | Link-training start level |
| stack_req_o | output | 1 | Stack quasi-reset release request |
| stack_ack_i | input | 1 | Stack release acknowledge |
| ssmb_req_o | output | 1 | Slave bus release request |
| ssmb_ack_i | input | 1 | Slave bus acknowledge |
| msmb_req_o | output | 1 | Master bus release request |
| msmb_ack_i | input | 1 | Master bus acknowledge |
| ld_req_o | output | 1 | Configuration-memory load request |
| ld_done_i | input | 1 | Load finished without error |
| ld_err_i | input | 1 | Load aborted on error |
| ld_err_code_i | input | CODE_W | Error code from loader |
| halt_clr_i | input | 1 | Halt clear from slave bus |
| mode_o | output | MODE_W | Latched mode |
| ssmb_addr_o | output | ADDR_W | Latched slave bus address |
| msmb_slow_o | output | 1 | Master bus speed select |
| halt_o | output | 1 | Halt status |
| done_o | output | 1 | Load phase done |
| err_o | output | 1 | Load error status |
| err_code_o | output | CODE_W | Recorded error code |
| timeout_o | output | 1 | Sticky deadline violation |
| core_rst_no | output | 1 | Core reset, active low |
| normal_o | output | 1 | Normal operation |

## Verification
A warm request is sent after straps have been changed on the pins. A design that re-latched them would show a new `mode_o`, and one that started the sequence before completing would show `pll_req_o` together with `warm_cpl_o`.

Fundamental reset is dropped in the middle of a PLL handshake. This exposes a sequencer that lingers or keeps stale status.

Random modes cover the test-mode and load-mode masks. These runs catch a stack or load request issued in the wrong modes or out of order.

Loader errors and a held halt pin check that the core stays in reset until the clear. Deliberately slow acknowledges on the PLL and stack channels confirm that each deadline trips the sticky flag.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WCPL, ST_PLL, ST_LINK, ST_HSAMP, ST_STACK, ST_SPEED,
    ST_SREL, ST_MREL, ST_LOAD, ST_HCHK, ST_HALT, ST_NORMAL
  } seq_state_e;
endpackage

// File: rtl/rstseq_straps.sv
module rstseq_straps #(
  parameter int MODE_W = 4,
  parameter int ADDR_W = 4,
  parameter logic [(1<<MODE_W)-1:0] TEST_MASK = '0,
  parameter logic [(1<<MODE_W)-1:0] LOAD_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              slow_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              slow_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_test_o,
  output logic              needs_load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      slow_o <= 1'b0;
      addr_o <= '0;
    end else if (capture_i) begin
      mode_o <= mode_i;
      slow_o <= slow_i;
      addr_o <= addr_i;
    end
  end

  assign is_test_o    = TEST_MASK[mode_o];
  assign needs_load_o = LOAD_MASK[mode_o];

  a_r1_hold_straps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(mode_o) && $stable(addr_o) && $stable(slow_o));
endmodule

// File: rtl/rstseq_deadline.sv
module rstseq_deadline #(
  parameter int LT_TICKS  = 20,
  parameter int CFG_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  input  logic tick_i,
  input  logic link_up_i,
  input  logic cfg_need_i,
  input  logic cfg_up_i,
  output logic timeout_o
);
  localparam int MAXT  = (CFG_TICKS > LT_TICKS) ? CFG_TICKS : LT_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] LT_LIM  = CNT_W'(LT_TICKS);
  localparam logic [CNT_W-1:0] CFG_LIM = CNT_W'(CFG_TICKS);
  localparam logic [CNT_W-1:0] SAT     = CNT_W'(MAXT);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             late;

  assign late = active_q &&
                ((cnt_q >= LT_LIM && !link_up_i) ||
                 (cfg_need_i && cnt_q >= CFG_LIM && !cfg_up_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      active_q  <= 1'b0;
      timeout_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q     <= '0;
      active_q  <= 1'b0;
      timeout_o <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else begin
      if (active_q && tick_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      if (late) timeout_o <= 1'b1;
    end
  end

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !clear_i |=> timeout_o);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !timeout_o);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int MODE_W    = 4,
  parameter int ADDR_W    = 4,
  parameter int CODE_W    = 4,
  parameter int LT_TICKS  = 20,
  parameter int CFG_TICKS = 100,
  parameter logic [(1<<MODE_W)-1:0] TEST_MASK = 16'hC000,
  parameter logic [(1<<MODE_W)-1:0] LOAD_MASK = 16'h0006
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fund_rst_ni,
  input  logic              warm_req_i,
  output logic              warm_cpl_o,
  input  logic [MODE_W-1:0] strap_mode_i,
  input  logic              strap_slow_i,
  input  logic [ADDR_W-1:0] strap_addr_i,
  input  logic              halt_pin_i,
  input  logic              tick_i,
  output logic              pll_req_o,
  input  logic              pll_ack_i,
  output logic              link_train_o,
  output logic              stack_req_o,
  input  logic              stack_ack_i,
  output logic              ssmb_req_o,
  input  logic              ssmb_ack_i,
  output logic              msmb_req_o,
  input  logic              msmb_ack_i,
  output logic              ld_req_o,
  input  logic              ld_done_i,
  input  logic              ld_err_i,
  input  logic [CODE_W-1:0] ld_err_code_i,
  input  logic              halt_clr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [ADDR_W-1:0] ssmb_addr_o,
  output logic              msmb_slow_o,
  output logic              halt_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              timeout_o,
  output logic              core_rst_no,
  output logic              normal_o
);
  seq_state_e state_q;
  logic fund_q, capture, warm_go;
  logic strap_slow, is_test, needs_load;
  logic link_q, stack_up_q, ssmb_up_q;

  assign capture = fund_rst_ni & ~fund_q;
  assign warm_go = warm_req_i && state_q != ST_IDLE && state_q != ST_WCPL;

  rstseq_straps #(
    .MODE_W(MODE_W), .ADDR_W(ADDR_W),
    .TEST_MASK(TEST_MASK), .LOAD_MASK(LOAD_MASK)
  ) u_straps (
    .clk_i, .rst_ni,
    .capture_i   (capture),
    .mode_i      (strap_mode_i),
    .slow_i      (strap_slow_i),
    .addr_i      (strap_addr_i),
    .mode_o      (mode_o),
    .slow_o      (strap_slow),
    .addr_o      (ssmb_addr_o),
    .is_test_o   (is_test),
    .needs_load_o(needs_load)
  );

  rstseq_deadline #(.LT_TICKS(LT_TICKS), .CFG_TICKS(CFG_TICKS)) u_deadline (
    .clk_i, .rst_ni,
    .clear_i   (!fund_rst_ni),
    .start_i   (capture || state_q == ST_WCPL),
    .tick_i    (tick_i),
    .link_up_i (link_q),
    .cfg_need_i(!is_test),
    .cfg_up_i  (stack_up_q),
    .timeout_o (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fund_q      <= 1'b0;
      link_q      <= 1'b0;
      stack_up_q  <= 1'b0;
      ssmb_up_q   <= 1'b0;
      msmb_slow_o <= 1'b0;
      halt_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_code_o  <= '0;
    end else begin
      fund_q <= fund_rst_ni;
      if (!fund_rst_ni || warm_go) begin
        state_q     <= fund_rst_ni ? ST_WCPL : ST_IDLE;
        link_q      <= 1'b0;
        stack_up_q  <= 1'b0;
        ssmb_up_q   <= 1'b0;
        msmb_slow_o <= 1'b0;
        halt_o      <= 1'b0;
        done_o      <= 1'b0;
        err_o       <= 1'b0;
        err_code_o  <= '0;
      end else begin
        if (halt_clr_i && ssmb_up_q) halt_o <= 1'b0;
        unique case (state_q)
          ST_IDLE:   if (capture) state_q <= ST_PLL;
          ST_WCPL:   state_q <= ST_PLL;
          ST_PLL:    if (pll_ack_i) state_q <= ST_LINK;
          ST_LINK: begin
            link_q  <= 1'b1;             // training proceeds in background
            state_q <= ST_HSAMP;
          end
          ST_HSAMP: begin
            if (halt_pin_i) halt_o <= 1'b1;
            state_q <= ST_STACK;
          end
          ST_STACK: begin
            if (is_test) state_q <= ST_SPEED;
            else if (stack_ack_i) begin
              stack_up_q <= 1'b1;
              state_q    <= ST_SPEED;
            end
          end
          ST_SPEED: begin
            msmb_slow_o <= strap_slow;
            state_q     <= ST_SREL;
          end
          ST_SREL: if (ssmb_ack_i) begin
            ssmb_up_q <= 1'b1;
            state_q   <= ST_MREL;
          end
          ST_MREL:   if (msmb_ack_i) state_q <= ST_LOAD;
          ST_LOAD: begin
            if (!needs_load || ld_done_i) begin
              done_o  <= 1'b1;
              state_q <= ST_HCHK;
            end else if (ld_err_i) begin
              done_o     <= 1'b1;
              err_o      <= 1'b1;
              halt_o     <= 1'b1;
              err_code_o <= ld_err_code_i;
              state_q    <= ST_HCHK;
            end
          end
          ST_HCHK:   state_q <= halt_o ? ST_HALT : ST_NORMAL;
          ST_HALT:   if (halt_clr_i || !halt_o) state_q <= ST_NORMAL;
          ST_NORMAL: state_q <= ST_NORMAL;
          default:   state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign warm_cpl_o   = state_q == ST_WCPL;
  assign pll_req_o    = state_q == ST_PLL;
  assign stack_req_o  = state_q == ST_STACK && !is_test;
  assign ssmb_req_o   = state_q == ST_SREL;
  assign msmb_req_o   = state_q == ST_MREL;
  assign ld_req_o     = state_q == ST_LOAD && needs_load;
  assign link_train_o = link_q;
  assign normal_o     = state_q == ST_NORMAL;
  assign core_rst_no  = normal_o;

  a_r3_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pll_req_o, stack_req_o, ssmb_req_o, msmb_req_o, ld_req_o}));
  a_r3_pll_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_req_o && !pll_ack_i && fund_rst_ni && !warm_req_i |=> pll_req_o);
  a_r3_link_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_req_o || ssmb_req_o || ld_req_o) |-> link_train_o);
  a_r2_cpl_then_pll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_cpl_o && fund_rst_ni |=> pll_req_o);
  a_r2_keep_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_cpl_o |=> $stable(mode_o));
  a_r5_no_stack_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_req_o |-> !TEST_MASK[mode_o]);
  a_r8_err_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r9_halt_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !core_rst_no);
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fund_rst_ni |=> state_q == ST_IDLE && !done_o && !halt_o && !err_o);
endmodule

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;
  logic clk = 1'b0, rst_n = 1'b0, fund_n = 1'b0, warm_req = 1'b0;
  logic [3:0] s_mode = '0, s_addr = '0, ld_code = '0;
  logic s_slow = 1'b0, hpin = 1'b0, tick = 1'b0, hclr = 1'b0;
  logic pll_ack = 1'b0, stk_ack = 1'b0, ss_ack = 1'b0, ms_ack = 1'b0;
  logic ld_done = 1'b0, ld_err = 1'b0;
  logic warm_cpl, pll_req, link_tr, stk_req, ss_req, ms_req, ld_req;
  logic [3:0] mode_o, addr_o, code_o;
  logic slow_o, halt_o, done_o, err_o, tout_o, core_rn, normal_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int d_pll = 1, d_stk = 1, d_ss = 1, d_ms = 1, d_ld = 1;
  bit ld_fail = 0;
  int r_pll, r_lnk, r_stk, r_ss, r_ms, r_ld;
  logic [6:0] prev = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reset_sequencer u_reset_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .fund_rst_ni(fund_n), .warm_req_i(warm_req),
    .warm_cpl_o(warm_cpl), .strap_mode_i(s_mode), .strap_slow_i(s_slow),
    .strap_addr_i(s_addr), .halt_pin_i(hpin), .tick_i(tick),
    .pll_req_o(pll_req), .pll_ack_i(pll_ack), .link_train_o(link_tr),
    .stack_req_o(stk_req), .stack_ack_i(stk_ack), .ssmb_req_o(ss_req),
    .ssmb_ack_i(ss_ack), .msmb_req_o(ms_req), .msmb_ack_i(ms_ack),
    .ld_req_o(ld_req), .ld_done_i(ld_done), .ld_err_i(ld_err),
    .ld_err_code_i(ld_code), .halt_clr_i(hclr), .mode_o(mode_o),
    .ssmb_addr_o(addr_o), .msmb_slow_o(slow_o), .halt_o(halt_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(code_o), .timeout_o(tout_o),
    .core_rst_no(core_rn), .normal_o(normal_o));

  // rise recorder
  always @(negedge clk) begin
    if (pll_req && !prev[0]) r_pll = cyc;
    if (link_tr && !prev[1]) r_lnk = cyc;
    if (stk_req && !prev[2]) r_stk = cyc;
    if (ss_req  && !prev[3]) r_ss  = cyc;
    if (ms_req  && !prev[4]) r_ms  = cyc;
    if (ld_req  && !prev[5]) r_ld  = cyc;
    prev = {1'b0, ld_req, ms_req, ss_req, stk_req, link_tr, pll_req};
  end

  initial forever begin
    repeat (3) @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  end

  initial forever begin @(negedge clk); pll_ack = 0;
    if (pll_req) begin repeat (d_pll - 1) @(negedge clk); pll_ack = 1; end end
  initial forever begin @(negedge clk); stk_ack = 0;
    if (stk_req) begin repeat (d_stk - 1) @(negedge clk); stk_ack = 1; end end
  initial forever begin @(negedge clk); ss_ack = 0;
    if (ss_req) begin repeat (d_ss - 1) @(negedge clk); ss_ack = 1; end end
  initial forever begin @(negedge clk); ms_ack = 0;
    if (ms_req) begin repeat (d_ms - 1) @(negedge clk); ms_ack = 1; end end
  initial forever begin @(negedge clk); ld_done = 0; ld_err = 0;
    if (ld_req) begin repeat (d_ld - 1) @(negedge clk);
      if (ld_fail) ld_err = 1; else ld_done = 1; end end

  function automatic bit f_test(input logic [3:0] m); return m >= 4'd14; endfunction
  function automatic bit f_load(input logic [3:0] m); return m == 4'd1 || m == 4'd2; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done_o && k < 3000) begin @(negedge clk); k++; end
    chk(done_o, req, done_o, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_seq(input logic [3:0] m, input bit sl, input logic [3:0] a,
                         input bit hp, input bit lf, input logic [3:0] c);
    int t0;
    bit e_halt, e_err;
    @(negedge clk);
    fund_n = 0; s_mode = m; s_slow = sl; s_addr = a; hpin = hp;
    ld_fail = lf; ld_code = c;
    @(negedge clk);
    chk(!pll_req && !done_o && !halt_o && !tout_o, "R10", done_o, 0);
    repeat (2) @(negedge clk);
    fund_n = 1; t0 = cyc;
    wait_done("R7");
    hpin = 0;
    e_err  = lf && f_load(m);
    e_halt = hp || e_err;
    chk(mode_o == m, "R1", mode_o, m);
    chk(addr_o == a, "R1", addr_o, a);
    chk(slow_o == sl, "R6", slow_o, sl);
    chk(r_pll >= t0 && r_lnk > r_pll, "R3", r_lnk, r_pll + 1);
    if (f_test(m)) chk(r_stk < t0, "R5", r_stk, -1);
    else chk(r_stk > r_lnk && r_ss > r_stk, "R5", r_stk, r_lnk + 1);
    chk(r_ss > r_lnk && r_ms > r_ss, "R3", r_ms, r_ss + 1);
    if (f_load(m)) chk(r_ld > r_ms, "R7", r_ld, r_ms + 1);
    else chk(r_ld < t0, "R7", r_ld, -1);
    chk(err_o == e_err, "R8", err_o, e_err);
    if (e_err) chk(code_o == c, "R8", code_o, c);
    chk(halt_o == e_halt, "R4", halt_o, e_halt);
    chk(tout_o == 0, "R11", tout_o, 0);
    if (e_halt) begin
      chk(!core_rn && !normal_o, "R9", core_rn, 0);
      hclr = 1; @(negedge clk); hclr = 0;
      chk(normal_o && !halt_o, "R9", normal_o, 1);
    end
    chk(normal_o && core_rn, "R12", normal_o, 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t1;
    void'($urandom(32'd7717));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!pll_req && !normal_o && !core_rn && !done_o, "R10", normal_o, 0);

    // directed corners
    run_seq(4'd0, 1'b1, 4'hA, 1'b0, 1'b0, 4'h0);
    run_seq(4'd1, 1'b0, 4'h3, 1'b0, 1'b1, 4'h9);   // load error
    run_seq(4'd15, 1'b0, 4'h5, 1'b1, 1'b0, 4'h0);  // test mode + halt pin
    run_seq(4'd2, 1'b1, 4'hC, 1'b0, 1'b0, 4'h0);

    // warm reset reuses straps
    s_mode = 4'd14; s_slow = 0; s_addr = 4'h1;
    warm_req = 1; @(negedge clk); warm_req = 0;
    chk(warm_cpl && !pll_req, "R2", warm_cpl, 1);
    @(negedge clk);
    chk(pll_req && !warm_cpl, "R2", pll_req, 1);
    t1 = cyc;
    wait_done("R2");
    chk(mode_o == 4'd2 && addr_o == 4'hC && slow_o, "R2", mode_o, 2);
    chk(r_ld > t1 && normal_o, "R2", r_ld, t1 + 1);

    // fundamental reset mid handshake
    d_pll = 40;
    @(negedge clk); fund_n = 0; @(negedge clk); fund_n = 1; s_mode = 4'd3;
    repeat (6) @(negedge clk);
    chk(pll_req, "R3", pll_req, 1);
    fund_n = 0; @(negedge clk);
    chk(!pll_req && !done_o && !link_tr, "R10", pll_req, 0);
    repeat (50) @(negedge clk);

    // link-training deadline
    d_pll = 120;
    fund_n = 1; repeat (110) @(negedge clk);
    chk(tout_o, "R11", tout_o, 1);
    repeat (20) @(negedge clk);
    chk(tout_o, "R11", tout_o, 1);
    fund_n = 0; @(negedge clk);
    chk(!tout_o, "R10", tout_o, 0);
    repeat (20) @(negedge clk);
    d_pll = 1;

    // stack deadline
    d_stk = 450; s_mode = 4'd0;
    fund_n = 1; repeat (430) @(negedge clk);
    chk(tout_o && stk_req, "R11", tout_o, 1);
    fund_n = 0; repeat (30) @(negedge clk);
    d_stk = 1;

    // random
    for (int i = 0; i < 25; i++) begin
      d_pll = 1 + $urandom_range(0, 3); d_stk = 1 + $urandom_range(0, 3);
      d_ss = 1 + $urandom_range(0, 3);  d_ms = 1 + $urandom_range(0, 3);
      d_ld = 1 + $urandom_range(0, 4);
      run_seq(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
              4'($urandom_range(0, 15)), $urandom_range(0, 3) == 0,
              $urandom_range(0, 2) == 0, 4'($urandom_range(1, 15)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule